// File: doc/BRIEF.md
# Iterative Integer Multiply-Divide Unit

This block computes 32-bit integer products and quotients for a processor core. Each result lands in a pair of dedicated result registers, `hi` and `lo`, which sit apart from the general register file. A caller pulses `start` with an opcode and two operands. The unit then raises `busy` and steps through a radix-2 shift-add sequence (multiply) or a restoring shift-subtract sequence (divide), one bit per clock.

When the sequence finishes, `hi` and `lo` are loaded together in the same cycle that `busy` drops. A product writes its upper half into `hi` and its lower half into `lo`. A division writes the remainder into `hi` and the quotient into `lo`. Signed operations work on operand magnitudes and fix the signs of the results at the end: the quotient is truncated toward zero and the remainder carries the sign of the dividend.

The unit raises no overflow or divide-by-zero indication. A zero divisor still produces a defined result. Move-from instructions read the two registers on their own output ports. Move-to instructions write either register directly through a shared data input.

Top module: `mdu_core`

## Requirements
- R1: The opcode encoding is 00 signed multiply, 01 unsigned multiply, 10 signed divide, 11 unsigned divide. A `start` seen while idle is accepted at that clock edge. `busy` then reads high from the next cycle and stays high for exactly 32 cycles.
- R2: Unsigned multiply treats both operands as unsigned. It leaves the upper 32 bits of the 64-bit product in `hi` and the lower 32 bits in `lo`.
- R3: Signed multiply treats both operands as two's complement. It leaves the 64-bit two's complement product split the same way as R2.
- R4: Unsigned divide leaves the quotient in `lo` and the remainder in `hi`, so that dividend = quotient × divisor + remainder and remainder < divisor.
- R5: Signed divide truncates the quotient toward zero. The remainder takes the sign of the dividend.
- R6: With a zero divisor, either divide completes normally, with `lo` all ones and `hi` equal to the raw dividend.
- R7: A `start` that arrives while `busy` is high is ignored. The running operation's result and its 32-cycle length are unchanged, and no new operation begins after it.
- R8: While an operation runs, `hi` and `lo` change only through a direct write. The computed result updates both registers together in the cycle `busy` falls.
- R9: When no result completes, `wr_hi` loads `wr_data` into `hi` at the next edge and `wr_lo` loads it into `lo`. Each write leaves the other register unchanged.
- R10: When a direct write falls in the same cycle as a result completing, the computed result wins for both registers.
- R11: No overflow is flagged. A signed divide of 0x80000000 by 0xFFFFFFFF gives `lo` = 0x80000000 and `hi` = 0.
- R12: After reset, `busy` is low and `hi` and `lo` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when idle |
| op | input | 2 | Operation select (see R1) |
| src_a | input | 32 | Multiplicand or dividend |
| src_b | input | 32 | Multiplier or divisor |
| wr_hi | input | 1 | Direct write of `wr_data` into hi |
| wr_lo | input | 1 | Direct write of `wr_data` into lo |
| wr_data | input | 32 | Data for direct writes |
| busy | output | 1 | Operation in progress |
| hi_q | output | 32 | hi register (upper product / remainder) |
| lo_q | output | 32 | lo register (lower product / quotient) |

## Verification
Two events can land in the same cycle: the sequence committing its result and a move-to write into `hi` and `lo`. The bench starts a multiply, counts 31 cycles of `busy`, and then asserts both direct-write strobes with a marker value during the final busy cycle. It judges the outcome one cycle later by expecting the computed product in both registers and `busy` low. A second collision, `start` held high while the unit is running, is judged by the unchanged run length and the first operation's result.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  typedef enum logic [1:0] {
    OP_MUL_S = 2'b00,
    OP_MUL_U = 2'b01,
    OP_DIV_S = 2'b10,
    OP_DIV_U = 2'b11
  } mdu_op_e;

  function automatic logic op_is_div(mdu_op_e o);
    return (o == OP_DIV_S) || (o == OP_DIV_U);
  endfunction

  function automatic logic op_is_signed(mdu_op_e o);
    return (o == OP_MUL_S) || (o == OP_DIV_S);
  endfunction

endpackage

// File: rtl/mdu_mul_seq.sv
// Radix-2 shift-add multiplier datapath over unsigned magnitudes.
module mdu_mul_seq #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [W-1:0]   mcand_in,
  input  logic [W-1:0]   mplier_in,
  output logic [2*W-1:0] prod_nxt
);
  localparam int AW = 2 * W + 1;

  logic [AW-1:0] acc_q;
  logic [AW-1:0] acc_nxt;
  logic [W-1:0]  mcand_q;

  // one iteration: add multiplicand if low bit set, then shift right
  function automatic logic [AW-1:0] mul_step(logic [AW-1:0] acc, logic [W-1:0] mc);
    logic [W:0] sum;
    sum = acc[AW-1:W] + (acc[0] ? {1'b0, mc} : {(W+1){1'b0}});
    return {1'b0, sum, acc[W-1:1]};
  endfunction

  assign acc_nxt  = mul_step(acc_q, mcand_q);
  assign prod_nxt = acc_nxt[2*W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q   <= '0;
      mcand_q <= '0;
    end else if (load) begin
      acc_q   <= {{(W+1){1'b0}}, mplier_in};
      mcand_q <= mcand_in;
    end else if (step) begin
      acc_q   <= acc_nxt;
    end
  end
endmodule

// File: rtl/mdu_div_seq.sv
// Restoring shift-subtract divider datapath over unsigned magnitudes.
module mdu_div_seq #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] dvd_in,
  input  logic [W-1:0] dsr_in,
  output logic [W-1:0] quo_nxt,
  output logic [W-1:0] rem_nxt
);
  logic [W-1:0] rem_q, quo_q, dsr_q;

  // one iteration: shift in next dividend bit, subtract if it fits
  function automatic logic [2*W-1:0] div_step(logic [W-1:0] rem, logic [W-1:0] quo,
                                              logic [W-1:0] dsr);
    logic [W:0]   r;
    logic [W-1:0] q;
    r = {rem, quo[W-1]};
    q = {quo[W-2:0], 1'b0};
    if (r >= {1'b0, dsr}) begin
      r    = r - {1'b0, dsr};
      q[0] = 1'b1;
    end
    return {r[W-1:0], q};
  endfunction

  assign {rem_nxt, quo_nxt} = div_step(rem_q, quo_q, dsr_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dsr_q <= '0;
    end else if (load) begin
      rem_q <= '0;
      quo_q <= dvd_in;
      dsr_q <= dsr_in;
    end else if (step) begin
      rem_q <= rem_nxt;
      quo_q <= quo_nxt;
    end
  end
endmodule

// File: rtl/mdu_hilo_regs.sv
// Result register pair; a completing result outranks direct writes.
module mdu_hilo_regs #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         commit,
  input  logic [W-1:0] res_hi,
  input  logic [W-1:0] res_lo,
  input  logic         wr_hi,
  input  logic         wr_lo,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] hi_q,
  output logic [W-1:0] lo_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (commit) begin
      hi_q <= res_hi;
      lo_q <= res_lo;
    end else begin
      if (wr_hi) hi_q <= wr_data;
      if (wr_lo) lo_q <= wr_data;
    end
  end
endmodule

// File: rtl/mdu_core.sv
module mdu_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] src_a,
  input  logic [W-1:0] src_b,
  input  logic         wr_hi,
  input  logic         wr_lo,
  input  logic [W-1:0] wr_data,
  output logic         busy,
  output logic [W-1:0] hi_q,
  output logic [W-1:0] lo_q
);
  import mdu_pkg::*;

  localparam int          CW   = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  function automatic logic [W-1:0] magnitude(logic [W-1:0] x, logic sgn);
    return (sgn && x[W-1]) ? (~x + 1'b1) : x;
  endfunction

  function automatic logic [W-1:0] neg_if(logic [W-1:0] x, logic n);
    return n ? (~x + 1'b1) : x;
  endfunction

  function automatic logic [2*W-1:0] neg_if_wide(logic [2*W-1:0] x, logic n);
    return n ? (~x + 1'b1) : x;
  endfunction

  mdu_op_e op_sel;
  logic    op_div, op_sgn;

  // named events for the checker
  logic accept;
  logic done;

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic          is_div_q, div_zero_q;
  logic          neg_prod_q, neg_quo_q, neg_rem_q;
  logic [W-1:0]  a_raw_q;

  logic [W-1:0]   mag_a, mag_b;
  logic [2*W-1:0] prod_nxt;
  logic [W-1:0]   quo_nxt, rem_nxt;
  logic [2*W-1:0] prod_fix;
  logic [W-1:0]   res_hi, res_lo;

  assign op_sel = mdu_op_e'(op);
  assign op_div = op_is_div(op_sel);
  assign op_sgn = op_is_signed(op_sel);

  assign accept = start & ~busy_q;
  assign done   = busy_q & (cnt_q == LAST);
  assign busy   = busy_q;

  assign mag_a = magnitude(src_a, op_sgn);
  assign mag_b = magnitude(src_b, op_sgn);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      cnt_q      <= '0;
      is_div_q   <= 1'b0;
      div_zero_q <= 1'b0;
      neg_prod_q <= 1'b0;
      neg_quo_q  <= 1'b0;
      neg_rem_q  <= 1'b0;
      a_raw_q    <= '0;
    end else if (accept) begin
      busy_q     <= 1'b1;
      cnt_q      <= '0;
      is_div_q   <= op_div;
      div_zero_q <= (src_b == '0);
      neg_prod_q <= op_sgn & ~op_div & (src_a[W-1] ^ src_b[W-1]);
      neg_quo_q  <= op_sgn &  op_div & (src_a[W-1] ^ src_b[W-1]);
      neg_rem_q  <= op_sgn &  op_div & src_a[W-1];
      a_raw_q    <= src_a;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (done) busy_q <= 1'b0;
    end
  end

  mdu_mul_seq #(.W(W)) u_mul (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .step     (busy_q),
    .mcand_in (mag_a),
    .mplier_in(mag_b),
    .prod_nxt (prod_nxt)
  );

  mdu_div_seq #(.W(W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .step   (busy_q),
    .dvd_in (mag_a),
    .dsr_in (mag_b),
    .quo_nxt(quo_nxt),
    .rem_nxt(rem_nxt)
  );

  assign prod_fix = neg_if_wide(prod_nxt, neg_prod_q);

  always_comb begin
    if (is_div_q) begin
      if (div_zero_q) begin
        res_hi = a_raw_q;
        res_lo = '1;
      end else begin
        res_hi = neg_if(rem_nxt, neg_rem_q);
        res_lo = neg_if(quo_nxt, neg_quo_q);
      end
    end else begin
      res_hi = prod_fix[2*W-1:W];
      res_lo = prod_fix[W-1:0];
    end
  end

  mdu_hilo_regs #(.W(W)) u_hilo (
    .clk    (clk),
    .rst_n  (rst_n),
    .commit (done),
    .res_hi (res_hi),
    .res_lo (res_lo),
    .wr_hi  (wr_hi),
    .wr_lo  (wr_lo),
    .wr_data(wr_data),
    .hi_q   (hi_q),
    .lo_q   (lo_q)
  );
endmodule

// File: rtl/mdu_chk.sv
module mdu_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         accept,
  input logic         done,
  input logic         wr_hi,
  input logic         wr_lo,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] hi_q,
  input logic [W-1:0] lo_q,
  input logic         is_div_q,
  input logic         div_zero_q
);
  localparam int LW = $clog2(W) + 2;

  logic [LW-1:0] run_len;

  always_ff @(posedge clk) begin
    if (!rst_n)      run_len <= '0;
    else if (accept) run_len <= '0;
    else if (busy)   run_len <= run_len + 1'b1;
  end

  // R1
  start_to_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  // R1
  run_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == LW'(W)));

  // R7
  restart_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !done) |=> (busy && run_len == $past(run_len) + 1'b1));

  // R8
  hold_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && !wr_hi) |=> $stable(hi_q));

  // R8
  hold_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && !wr_lo) |=> $stable(lo_q));

  // R9
  direct_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !done) |=> (hi_q == $past(wr_data)));

  // R9
  direct_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !done) |=> (lo_q == $past(wr_data)));

  // R6
  div_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && is_div_q && div_zero_q) |=> (lo_q == '1));
endmodule

bind mdu_core mdu_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .accept    (accept),
  .done      (done),
  .wr_hi     (wr_hi),
  .wr_lo     (wr_lo),
  .wr_data   (wr_data),
  .hi_q      (hi_q),
  .lo_q      (lo_q),
  .is_div_q  (is_div_q),
  .div_zero_q(div_zero_q)
);

// File: tb/sim_mdu_core.sv
module sim_mdu_core;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic [1:0]   op;
  logic [W-1:0] src_a, src_b;
  logic         wr_hi, wr_lo;
  logic [W-1:0] wr_data;
  logic         busy;
  logic [W-1:0] hi_q, lo_q;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mdu_core #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .src_a(src_a), .src_b(src_b), .wr_hi(wr_hi), .wr_lo(wr_lo),
    .wr_data(wr_data), .busy(busy), .hi_q(hi_q), .lo_q(lo_q)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected {hi, lo} restated from the requirements
  function automatic logic [63:0] expect_hilo(logic [1:0] o, logic [31:0] a, logic [31:0] b);
    longint sa, sb, q, r;
    logic [63:0] ua, ub;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    ua = {32'd0, a};
    ub = {32'd0, b};
    case (o)
      2'b00: return 64'(sa * sb);
      2'b01: return ua * ub;
      2'b10: begin
        if (b == 0) return {a, 32'hFFFF_FFFF};
        q = sa / sb;
        r = sa % sb;
        return {r[31:0], q[31:0]};
      end
      default: begin
        if (b == 0) return {a, 32'hFFFF_FFFF};
        return {32'(ua % ub), 32'(ua / ub)};
      end
    endcase
  endfunction

  task automatic run_op(string req, logic [1:0] o, logic [31:0] a, logic [31:0] b);
    logic [31:0] hi0, lo0;
    int n;
    bit moved;
    @(negedge clk);
    start = 1'b1; op = o; src_a = a; src_b = b;
    @(negedge clk);
    start = 1'b0;
    hi0 = hi_q; lo0 = lo_q;
    check("R1 busy after start", 64'(busy), 64'd1);
    n = 0;
    moved = 1'b0;
    while (busy && n < 100) begin
      if (hi_q !== hi0 || lo_q !== lo0) moved = 1'b1;
      @(negedge clk);
      n++;
    end
    check("R8 hi/lo held while busy", 64'(moved), 64'd0);
    check("R1 busy length", 64'(n), 64'd32);
    check(req, {hi_q, lo_q}, expect_hilo(o, a, b));
  endtask

  task automatic t_reset();
    check("R12 busy after reset", 64'(busy), 64'd0);
    check("R12 hi/lo after reset", {hi_q, lo_q}, 64'd0);
  endtask

  task automatic t_mul_unsigned();
    run_op("R2 unsigned multiply max", 2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run_op("R2 unsigned multiply mixed", 2'b01, 32'h1234_5678, 32'h9ABC_DEF0);
  endtask

  task automatic t_mul_signed();
    run_op("R3 signed multiply neg*pos", 2'b00, 32'hFFFF_FFFD, 32'd7);
    run_op("R3 signed multiply min*min", 2'b00, 32'h8000_0000, 32'h8000_0000);
    run_op("R3 signed multiply neg*neg", 2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
  endtask

  task automatic t_div_unsigned();
    run_op("R4 unsigned divide 100/7", 2'b11, 32'd100, 32'd7);
    run_op("R4 unsigned divide large", 2'b11, 32'hFFFF_FFFF, 32'h10);
    run_op("R4 unsigned divide small dividend", 2'b11, 32'd5, 32'd9);
  endtask

  task automatic t_div_signed();
    run_op("R5 signed divide -7/2", 2'b10, 32'hFFFF_FFF9, 32'd2);
    check("R5 -7/2 explicit", {hi_q, lo_q}, {32'hFFFF_FFFF, 32'hFFFF_FFFD});
    run_op("R5 signed divide 7/-2", 2'b10, 32'd7, 32'hFFFF_FFFE);
    run_op("R5 signed divide -7/-2", 2'b10, 32'hFFFF_FFF9, 32'hFFFF_FFFE);
  endtask

  task automatic t_div_zero();
    run_op("R6 signed divide by zero", 2'b10, 32'hFFFF_FFFB, 32'd0);
    run_op("R6 unsigned divide by zero", 2'b11, 32'd123, 32'd0);
  endtask

  task automatic t_no_overflow();
    run_op("R11 most negative by minus one", 2'b10, 32'h8000_0000, 32'hFFFF_FFFF);
    check("R11 explicit", {hi_q, lo_q}, {32'd0, 32'h8000_0000});
  endtask

  task automatic t_start_while_busy();
    int n;
    @(negedge clk);
    start = 1'b1; op = 2'b01; src_a = 32'd6; src_b = 32'd7;
    @(negedge clk);
    op = 2'b11; src_a = 32'd100; src_b = 32'd3;
    n = 0;
    while (busy && n < 100) begin
      @(negedge clk);
      n++;
      if (n == 5) start = 1'b0;
    end
    check("R7 run length with extra start", 64'(n), 64'd32);
    check("R7 first result kept", {hi_q, lo_q}, 64'd42);
    @(negedge clk);
    check("R7 no restart afterwards", 64'(busy), 64'd0);
  endtask

  task automatic t_direct_write();
    logic [31:0] lo0, hi0;
    lo0 = lo_q;
    @(negedge clk);
    wr_hi = 1'b1; wr_data = 32'hA5A5_0001;
    @(negedge clk);
    wr_hi = 1'b0;
    check("R9 hi direct write", {hi_q, lo_q}, {32'hA5A5_0001, lo0});
    hi0 = hi_q;
    wr_lo = 1'b1; wr_data = 32'h5A5A_0002;
    @(negedge clk);
    wr_lo = 1'b0;
    check("R9 lo direct write", {hi_q, lo_q}, {hi0, 32'h5A5A_0002});
  endtask

  task automatic t_collision();
    @(negedge clk);
    start = 1'b1; op = 2'b01; src_a = 32'd3; src_b = 32'd5;
    @(negedge clk);
    start = 1'b0;
    repeat (31) @(negedge clk);
    wr_hi = 1'b1; wr_lo = 1'b1; wr_data = 32'hDEAD_BEEF;
    @(negedge clk);
    wr_hi = 1'b0; wr_lo = 1'b0;
    check("R10 busy low after collision", 64'(busy), 64'd0);
    check("R10 result beats direct write", {hi_q, lo_q}, 64'd15);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; op = 2'b00; src_a = '0; src_b = '0;
    wr_hi = 1'b0; wr_lo = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mul_unsigned();
    t_mul_signed();
    t_div_unsigned();
    t_div_signed();
    t_div_zero();
    t_no_overflow();
    t_start_while_busy();
    t_direct_write();
    t_collision();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule